// File: doc/BRIEF.md
# Path-Associative Trace Cache with Prefix Delivery

This block sits at the front of an instruction fetch path. Each line holds a trace: a run of up to sixteen dynamically consecutive instructions spanning up to three basic blocks. A trace is named by the address of its first instruction and by the taken/not-taken outcomes of the branches that close its inner blocks. Each cycle, the fetch unit presents a fetch address and a vector of predicted outcomes. One cycle later the block answers in one of three ways. On a full hit it delivers the whole trace. On a partial hit, where only the leading predictions agree with the stored outcomes, it delivers the instructions up to the end of the last agreeing block. On a miss it delivers nothing, and the fetch unit falls back to the ordinary instruction cache.

The set is chosen from the fetch address alone. The predictions take part only in the compare. Each set holds two ways, so two traces that start at the same address but follow different paths can both be held. Completed traces arrive through a fill port. A fill that names a trace already present rewrites it in place. Otherwise the fill takes a free way, or the least recently used one. After a full hit, the block also gives the next fetch address: the stored fall-through or target of the trace's last block, chosen by the prediction that follows the stored outcomes.

Top module: `trace_cache`

## Requirements
- R1: While reset is held, and on the first edge after it, rsp_valid, rsp_hit, rsp_full and rsp_next_valid are 0. rsp_count, rsp_blocks, rsp_next_addr and every rsp_insns lane are 0. After reset, no trace is held, so every lookup misses until a fill arrives.
- R2: A lookup presented with req_valid=1 on a clock edge is answered on the next edge with rsp_valid=1. rsp_valid is 0 after an edge on which req_valid was 0, and all other outputs are then 0.
- R3: A full hit requires three things: a held trace whose start equals req_addr, with n embedded outcomes (n = 0..2), and req_pred[b] equal to stored flag b for every b < n. A full hit gives rsp_hit=1, rsp_full=1, rsp_blocks=n+1, and rsp_count equal to the stored end count of block n. Prediction bits at positions n and above take no part in the match.
- R4: If the start matches but the first disagreement is at flag j < n, the result is a partial hit: rsp_hit=1, rsp_full=0, rsp_blocks=j+1, and rsp_count equal to the stored end count of block j.
- R5: On a hit, lane i of rsp_insns (bits 32i+31:32i) carries stored instruction i for i < rsp_count. Lanes at or above rsp_count are 0. On a miss, rsp_hit=0, rsp_count=0, rsp_blocks=0 and all lanes are 0.
- R6: The set index is address bits [6:2], and a hit needs the whole 32-bit start address to be equal. A trace at an address that shares the index but differs in any bit never hits.
- R7: Two traces with the same start and different outcomes are held in the two ways of one set at once, and each is returned when the predictions select its path.
- R8: When both ways match, the way with the larger rsp_count wins. On equal counts, the more recently used way wins.
- R9: On a full hit with n outcomes, rsp_next_valid=1 and rsp_next_addr is the stored target if req_pred[n]=1, else the stored fall-through. On a partial hit or a miss, rsp_next_valid=0 and rsp_next_addr=0.
- R10: A fill goes to the way in its set that already holds the same start, the same n and the same low n flags. Failing that, it goes to the lowest-numbered empty way. Failing that, it goes to the least recently used way. The filled way becomes most recently used.
- R11: A hit makes the chosen way most recently used. If a fill lands in the same set on the same edge, only the fill's update to recency takes effect. After reset, way 0 counts as the more recent.
- R12: A lookup and a fill on the same edge: the lookup is answered from the contents held before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup request this cycle |
| req_addr | input | 32 | Fetch address (byte address) |
| req_pred | input | 3 | Predicted outcomes, bit b for the branch closing block b |
| fill_valid | input | 1 | Write a trace this cycle |
| fill_start | input | 32 | Start address of the trace being written |
| fill_nbr | input | 2 | Number of embedded outcomes n (0..2) |
| fill_flags | input | 2 | Embedded outcomes, bit b for block b |
| fill_ends | input | 15 | Three 5-bit instruction counts, field b = count at the end of block b |
| fill_insns | input | 512 | Sixteen 32-bit instruction lanes |
| fill_fall | input | 32 | Fall-through address after the last block |
| fill_targ | input | 32 | Taken target after the last block |
| rsp_valid | output | 1 | Answer to last cycle's lookup |
| rsp_hit | output | 1 | Full or partial match |
| rsp_full | output | 1 | Every embedded outcome matched |
| rsp_count | output | 5 | Number of instructions delivered |
| rsp_blocks | output | 2 | Number of basic blocks delivered |
| rsp_insns | output | 512 | Delivered instructions, zero above rsp_count |
| rsp_next_valid | output | 1 | rsp_next_addr is meaningful |
| rsp_next_addr | output | 32 | Next fetch address after a full hit |

## Verification
The case that is hardest to reach from the ports is a set where both ways share a start address and both give matches of equal length. Here the winner depends only on recency, and recency was set by earlier hits and fills, some of which arrived on the same edge as a lookup to that set. The directed part of the stimulus builds exactly this state. It fills two traces at one start, reads with a prediction that fails on the first outcome, then flips recency with a hit and with a same-edge fill. A long random phase then draws fills and lookups from a pool of six start addresses in two sets. This keeps both ways contended and makes same-edge fill and lookup pairs frequent.

// File: rtl/tc_pkg.sv
// Package tc_pkg
// Holds the default geometry shared by the trace cache and its bench, and
// the classification of a single way's compare result.
// Assumes at least two blocks per trace and at least two ways per set.
package tc_pkg;
    localparam int TC_LINE_INSNS = 16;
    localparam int TC_BLOCKS     = 3;
    localparam int TC_SETS       = 32;
    localparam int TC_WAYS       = 2;
    localparam int TC_ADDR_W     = 32;
    localparam int TC_INSN_W     = 32;

    typedef enum logic [1:0] {
        MK_MISS = 2'd0,
        MK_PART = 2'd1,
        MK_FULL = 2'd2
    } match_kind_e;
endpackage

// File: rtl/tc_way_match.sv
// Module tc_way_match
// Compares one stored trace against a lookup. The trace matches when its
// start equals the fetch address. The number of leading stored outcomes
// that agree with the predictions then gives the delivered block and the
// instruction count at that block's end.
// Assumes line_nbr <= BLOCKS-1 and that the stored flags are masked above line_nbr.
module tc_way_match #(
    parameter  int BLOCKS = tc_pkg::TC_BLOCKS,
    parameter  int CNT_W  = 5,
    parameter  int ADDR_W = tc_pkg::TC_ADDR_W,
    localparam int FLAGS  = BLOCKS - 1,
    localparam int NBR_W  = $clog2(BLOCKS)
) (
    input  logic                    line_valid,
    input  logic [ADDR_W-1:0]       line_start,
    input  logic [NBR_W-1:0]        line_nbr,
    input  logic [FLAGS-1:0]        line_flags,
    input  logic [BLOCKS*CNT_W-1:0] line_ends,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [FLAGS-1:0]        req_pred,
    output tc_pkg::match_kind_e     kind,
    output logic [CNT_W-1:0]        len,
    output logic [NBR_W-1:0]        lead
);
    logic tag_ok;
    logic run;

    // Count the leading outcomes that agree, stopping at the first disagreement.
    always_comb begin
        lead = '0;
        run  = 1'b1;
        for (int b = 0; b < FLAGS; b++) begin
            if (run && (NBR_W'(b) < line_nbr) && (line_flags[b] == req_pred[b]))
                lead = lead + NBR_W'(1);
            else
                run = 1'b0;
        end
    end

    // Classify the compare and look up the instruction count at the prefix end.
    always_comb begin
        tag_ok = line_valid && (line_start == req_addr);
        len    = tag_ok ? line_ends[int'(lead)*CNT_W +: CNT_W] : '0;
        if (!tag_ok)               kind = tc_pkg::MK_MISS;
        else if (lead == line_nbr) kind = tc_pkg::MK_FULL;
        else                       kind = tc_pkg::MK_PART;
    end
endmodule

// File: rtl/tc_pick.sv
// Module tc_pick
// Chooses among the matching ways of a set. The longest delivered count
// wins, and equal counts go to the way with the smaller recency age
// (age 0 = most recent).
// Assumes ages within a set are distinct.
module tc_pick #(
    parameter  int WAYS  = tc_pkg::TC_WAYS,
    parameter  int CNT_W = 5,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]       way_hit,
    input  logic [WAYS*CNT_W-1:0] way_len,
    input  logic [WAYS*WAY_W-1:0] way_age,
    output logic                  any_hit,
    output logic [WAY_W-1:0]      sel
);
    logic [CNT_W-1:0] best_len;
    logic [WAY_W-1:0] best_age;

    // Scan the ways and keep the best candidate so far.
    always_comb begin
        any_hit  = 1'b0;
        sel      = '0;
        best_len = '0;
        best_age = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w] &&
                (!any_hit ||
                 (way_len[w*CNT_W +: CNT_W] > best_len) ||
                 ((way_len[w*CNT_W +: CNT_W] == best_len) &&
                  (way_age[w*WAY_W +: WAY_W] < best_age)))) begin
                any_hit  = 1'b1;
                sel      = WAY_W'(w);
                best_len = way_len[w*CNT_W +: CNT_W];
                best_age = way_age[w*WAY_W +: WAY_W];
            end
        end
    end
endmodule

// File: rtl/tc_lru.sv
// Module tc_lru
// Keeps a recency rank per way per set (0 = most recent). It serves the
// ranks of the lookup set, the victim way for the fill set, and applies
// touches from a hit and from a fill. When both touch one set, the fill
// wins. Reset ranks way w at age w.
// Assumes touch way indices are below WAYS.
module tc_lru #(
    parameter  int SETS  = tc_pkg::TC_SETS,
    parameter  int WAYS  = tc_pkg::TC_WAYS,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SET_W-1:0]      rd_set,
    output logic [WAYS*WAY_W-1:0] rd_ages,
    input  logic [SET_W-1:0]      vic_set,
    input  logic [WAYS-1:0]       vic_valid,
    output logic [WAY_W-1:0]      vic_way,
    input  logic                  hit_en,
    input  logic [SET_W-1:0]      hit_set,
    input  logic [WAY_W-1:0]      hit_way,
    input  logic                  fill_en,
    input  logic [SET_W-1:0]      fill_set,
    input  logic [WAY_W-1:0]      fill_way
);
    logic [WAYS*WAY_W-1:0] ages [SETS];
    logic                  vic_found;

    function automatic logic [WAYS*WAY_W-1:0] touch(
        input logic [WAYS*WAY_W-1:0] a, input logic [WAY_W-1:0] t);
        logic [WAY_W-1:0]      at;
        logic [WAYS*WAY_W-1:0] r;
        at = a[int'(t)*WAY_W +: WAY_W];
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == t)                r[w*WAY_W +: WAY_W] = '0;
            else if (a[w*WAY_W +: WAY_W] < at) r[w*WAY_W +: WAY_W] = a[w*WAY_W +: WAY_W] + WAY_W'(1);
            else                               r[w*WAY_W +: WAY_W] = a[w*WAY_W +: WAY_W];
        end
        return r;
    endfunction

    function automatic logic [WAYS*WAY_W-1:0] init_ages();
        logic [WAYS*WAY_W-1:0] r;
        for (int w = 0; w < WAYS; w++) r[w*WAY_W +: WAY_W] = WAY_W'(w);
        return r;
    endfunction

    // Reset ranks, then apply the hit touch unless a fill touches the same set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ages[s] <= init_ages();
        end else begin
            if (hit_en && !(fill_en && (fill_set == hit_set)))
                ages[hit_set] <= touch(ages[hit_set], hit_way);
            if (fill_en)
                ages[fill_set] <= touch(ages[fill_set], fill_way);
        end
    end

    assign rd_ages = ages[rd_set];

    // Victim: the lowest empty way, otherwise the way with the oldest rank.
    always_comb begin
        vic_way   = '0;
        vic_found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!vic_found && !vic_valid[w]) begin
                vic_way   = WAY_W'(w);
                vic_found = 1'b1;
            end
        end
        if (!vic_found) begin
            for (int w = 0; w < WAYS; w++)
                if (ages[vic_set][w*WAY_W +: WAY_W] == WAY_W'(WAYS - 1))
                    vic_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/trace_cache.sv
// Module trace_cache (top)
// A set-associative store of traces indexed by fetch address bits
// [SET_W+1:2]. It answers a lookup one cycle later with the full trace,
// the prefix up to the last agreeing block, or a miss. A fill rewrites a
// same-path trace in place, otherwise it takes an empty way or the least
// recently used one.
// Assumes fill_nbr <= BLOCKS-1, that fill_ends are non-decreasing and at
// most LINE_INSNS, and that addresses are 4-byte aligned.
module trace_cache #(
    parameter  int LINE_INSNS = tc_pkg::TC_LINE_INSNS,
    parameter  int BLOCKS     = tc_pkg::TC_BLOCKS,
    parameter  int SETS       = tc_pkg::TC_SETS,
    parameter  int WAYS       = tc_pkg::TC_WAYS,
    parameter  int ADDR_W     = tc_pkg::TC_ADDR_W,
    parameter  int INSN_W     = tc_pkg::TC_INSN_W,
    localparam int FLAGS      = BLOCKS - 1,
    localparam int NBR_W      = $clog2(BLOCKS),
    localparam int BLK_W      = $clog2(BLOCKS + 1),
    localparam int CNT_W      = $clog2(LINE_INSNS + 1),
    localparam int LINE_W     = LINE_INSNS * INSN_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [BLOCKS-1:0]       req_pred,
    input  logic                    fill_valid,
    input  logic [ADDR_W-1:0]       fill_start,
    input  logic [NBR_W-1:0]        fill_nbr,
    input  logic [FLAGS-1:0]        fill_flags,
    input  logic [BLOCKS*CNT_W-1:0] fill_ends,
    input  logic [LINE_W-1:0]       fill_insns,
    input  logic [ADDR_W-1:0]       fill_fall,
    input  logic [ADDR_W-1:0]       fill_targ,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic                    rsp_full,
    output logic [CNT_W-1:0]        rsp_count,
    output logic [BLK_W-1:0]        rsp_blocks,
    output logic [LINE_W-1:0]       rsp_insns,
    output logic                    rsp_next_valid,
    output logic [ADDR_W-1:0]       rsp_next_addr
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    // Line storage
    logic [SETS-1:0][WAYS-1:0] l_valid;
    logic [ADDR_W-1:0]         l_start [SETS][WAYS];
    logic [NBR_W-1:0]          l_nbr   [SETS][WAYS];
    logic [FLAGS-1:0]          l_flags [SETS][WAYS];
    logic [BLOCKS*CNT_W-1:0]   l_ends  [SETS][WAYS];
    logic [LINE_W-1:0]         l_insns [SETS][WAYS];
    logic [ADDR_W-1:0]         l_fall  [SETS][WAYS];
    logic [ADDR_W-1:0]         l_targ  [SETS][WAYS];

    logic [SET_W-1:0]       lk_set, fl_set;
    logic [WAYS-1:0]        way_hit, way_full;
    logic [WAYS*CNT_W-1:0]  way_len;
    logic [WAYS*NBR_W-1:0]  way_lead;
    logic [WAYS*WAY_W-1:0]  lk_ages;
    logic                   any_hit, hit_en;
    logic [WAY_W-1:0]       sel, vic_way, fl_way;
    logic [CNT_W-1:0]       sel_len;
    logic [NBR_W-1:0]       sel_lead, sel_nbr;
    logic                   sel_full;
    logic [FLAGS-1:0]       fl_flags_m;
    logic [WAYS-1:0]        fl_same;
    logic                   fl_found;
    logic [LINE_W-1:0]      out_insns;
    logic [ADDR_W-1:0]      out_next;

    assign lk_set = req_addr[SET_W+1:2];
    assign fl_set = fill_start[SET_W+1:2];

    // Per-way compare of the lookup set against the request.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tc_pkg::match_kind_e kind;
        tc_way_match #(.BLOCKS(BLOCKS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_match (
            .line_valid (l_valid[lk_set][w]),
            .line_start (l_start[lk_set][w]),
            .line_nbr   (l_nbr[lk_set][w]),
            .line_flags (l_flags[lk_set][w]),
            .line_ends  (l_ends[lk_set][w]),
            .req_addr   (req_addr),
            .req_pred   (req_pred[FLAGS-1:0]),
            .kind       (kind),
            .len        (way_len[w*CNT_W +: CNT_W]),
            .lead       (way_lead[w*NBR_W +: NBR_W])
        );
        assign way_hit[w]  = (kind != tc_pkg::MK_MISS);
        assign way_full[w] = (kind == tc_pkg::MK_FULL);
        // Does this way already hold the same path as the incoming fill?
        assign fl_same[w] = l_valid[fl_set][w] && (l_start[fl_set][w] == fill_start) &&
                            (l_nbr[fl_set][w] == fill_nbr) && (l_flags[fl_set][w] == fl_flags_m);
    end

    tc_pick #(.WAYS(WAYS), .CNT_W(CNT_W)) u_pick (
        .way_hit (way_hit),
        .way_len (way_len),
        .way_age (lk_ages),
        .any_hit (any_hit),
        .sel     (sel)
    );

    assign hit_en = req_valid && any_hit;

    tc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (lk_set),
        .rd_ages   (lk_ages),
        .vic_set   (fl_set),
        .vic_valid (l_valid[fl_set]),
        .vic_way   (vic_way),
        .hit_en    (hit_en),
        .hit_set   (lk_set),
        .hit_way   (sel),
        .fill_en   (fill_valid),
        .fill_set  (fl_set),
        .fill_way  (fl_way)
    );

    // Mask fill outcomes above the embedded branch count.
    always_comb begin
        for (int b = 0; b < FLAGS; b++)
            fl_flags_m[b] = fill_flags[b] && (NBR_W'(b) < fill_nbr);
    end

    // Fill target: the same-path way first, otherwise the victim.
    always_comb begin
        fl_way   = vic_way;
        fl_found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!fl_found && fl_same[w]) begin
                fl_way   = WAY_W'(w);
                fl_found = 1'b1;
            end
        end
    end

    // Gather the chosen way's result and mask the lanes past the prefix.
    always_comb begin
        sel_len  = way_len[int'(sel)*CNT_W +: CNT_W];
        sel_lead = way_lead[int'(sel)*NBR_W +: NBR_W];
        sel_full = way_full[sel];
        sel_nbr  = l_nbr[lk_set][sel];
        out_next = req_pred[sel_nbr] ? l_targ[lk_set][sel] : l_fall[lk_set][sel];
        for (int i = 0; i < LINE_INSNS; i++)
            out_insns[i*INSN_W +: INSN_W] = (CNT_W'(i) < sel_len) ?
                l_insns[lk_set][sel][i*INSN_W +: INSN_W] : '0;
    end

    // Valid bits: cleared on reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n)          l_valid <= '0;
        else if (fill_valid) l_valid[fl_set][fl_way] <= 1'b1;
    end

    // Payload write of a fill.
    always_ff @(posedge clk) begin
        if (fill_valid) begin
            l_start[fl_set][fl_way] <= fill_start;
            l_nbr[fl_set][fl_way]   <= fill_nbr;
            l_flags[fl_set][fl_way] <= fl_flags_m;
            l_ends[fl_set][fl_way]  <= fill_ends;
            l_insns[fl_set][fl_way] <= fill_insns;
            l_fall[fl_set][fl_way]  <= fill_fall;
            l_targ[fl_set][fl_way]  <= fill_targ;
        end
    end

    // Response register: one cycle after the request, zero when not a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_full       <= 1'b0;
            rsp_count      <= '0;
            rsp_blocks     <= '0;
            rsp_insns      <= '0;
            rsp_next_valid <= 1'b0;
            rsp_next_addr  <= '0;
        end else begin
            rsp_valid      <= req_valid;
            rsp_hit        <= hit_en;
            rsp_full       <= hit_en && sel_full;
            rsp_count      <= hit_en ? sel_len : '0;
            rsp_blocks     <= hit_en ? (BLK_W'(sel_lead) + BLK_W'(1)) : '0;
            rsp_insns      <= hit_en ? out_insns : '0;
            rsp_next_valid <= hit_en && sel_full;
            rsp_next_addr  <= (hit_en && sel_full) ? out_next : '0;
        end
    end
endmodule

// File: rtl/tc_checker.sv
// Module tc_checker
// Port-level properties of trace_cache, attached to it with a bind.
// Assumes the top's default geometry is passed down through parameters.
module tc_checker #(
    parameter int BLOCKS = 3,
    parameter int CNT_W  = 5,
    parameter int BLK_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_full,
    input logic [CNT_W-1:0] rsp_count,
    input logic [BLK_W-1:0] rsp_blocks,
    input logic             rsp_next_valid
);
    a_r2_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_next_valid && rsp_count == '0));
    a_r3_full_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_full |-> rsp_hit);
    a_r5_miss_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_count == '0 && rsp_blocks == '0));
    a_r4_partial_short: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && !rsp_full) |-> (rsp_blocks >= BLK_W'(1) && rsp_blocks < BLK_W'(BLOCKS)));
    a_r9_next_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_next_valid == rsp_full);
endmodule

bind trace_cache tc_checker #(.BLOCKS(BLOCKS), .CNT_W(CNT_W), .BLK_W(BLK_W)) u_tc_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_full       (rsp_full),
    .rsp_count      (rsp_count),
    .rsp_blocks     (rsp_blocks),
    .rsp_next_valid (rsp_next_valid)
);

// File: tb/tb_trace_cache.sv
// Bench for trace_cache: a behavioural model with timestamp recency,
// compared with every output after every clock.
module tb_trace_cache;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic [31:0]  req_addr;
    logic [2:0]   req_pred;
    logic         fill_valid;
    logic [31:0]  fill_start;
    logic [1:0]   fill_nbr;
    logic [1:0]   fill_flags;
    logic [14:0]  fill_ends;
    logic [511:0] fill_insns;
    logic [31:0]  fill_fall;
    logic [31:0]  fill_targ;
    logic         rsp_valid, rsp_hit, rsp_full, rsp_next_valid;
    logic [4:0]   rsp_count;
    logic [1:0]   rsp_blocks;
    logic [511:0] rsp_insns;
    logic [31:0]  rsp_next_addr;

    always #4 clk = ~clk;

    trace_cache dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_pred(req_pred), .fill_valid(fill_valid), .fill_start(fill_start),
        .fill_nbr(fill_nbr), .fill_flags(fill_flags), .fill_ends(fill_ends),
        .fill_insns(fill_insns), .fill_fall(fill_fall), .fill_targ(fill_targ),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_full(rsp_full),
        .rsp_count(rsp_count), .rsp_blocks(rsp_blocks), .rsp_insns(rsp_insns),
        .rsp_next_valid(rsp_next_valid), .rsp_next_addr(rsp_next_addr)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Model state
    bit          m_v     [32][2];
    logic [31:0] m_start [32][2];
    int          m_nbr   [32][2];
    logic [1:0]  m_flags [32][2];
    int          m_ends  [32][2][3];
    logic [15:0] m_seed  [32][2];
    logic [31:0] m_fall  [32][2];
    logic [31:0] m_targ  [32][2];
    longint      m_stamp [32][2];
    longint      now = 0;
    logic [15:0] cur_seed;

    function automatic logic [1:0] mask_flags(logic [1:0] f, int n);
        logic [1:0] r;
        for (int b = 0; b < 2; b++) r[b] = f[b] && (b < n);
        return r;
    endfunction

    task automatic set_fill(input logic [31:0] st, input int n, input logic [1:0] f,
                            input int e0, input int e1, input int e2, input logic [15:0] seed,
                            input logic [31:0] fa, input logic [31:0] ta);
        fill_valid = 1'b1;
        fill_start = st;
        fill_nbr   = 2'(n);
        fill_flags = f;
        fill_ends  = {5'(e2), 5'(e1), 5'(e0)};
        for (int i = 0; i < 16; i++) fill_insns[i*32 +: 32] = {seed, 16'(i)};
        cur_seed   = seed;
        fill_fall  = fa;
        fill_targ  = ta;
    endtask

    task automatic set_look(input logic [31:0] a, input logic [2:0] p);
        req_valid = 1'b1;
        req_addr  = a;
        req_pred  = p;
    endtask

    task automatic idle();
        req_valid  = 1'b0;
        fill_valid = 1'b0;
    endtask

    // One clock: predict outputs, update the model, then compare after the edge.
    task automatic cyc(input string tag);
        bit e_valid, e_hit, e_full, e_nv;
        int e_count, e_blocks;
        logic [31:0] e_next;
        logic [511:0] e_insns;
        int set, fs, best_w, best_len, best_l, fw;
        bit found, ok;
        e_valid = 0; e_hit = 0; e_full = 0; e_nv = 0;
        e_count = 0; e_blocks = 0; e_next = '0; e_insns = '0;
        best_w = 0; best_len = 0; best_l = 0; found = 0;
        set = int'(req_addr[6:2]);
        now++;
        if (!rst_n) begin
            for (int s = 0; s < 32; s++)
                for (int w = 0; w < 2; w++) begin
                    m_v[s][w] = 0;
                    m_stamp[s][w] = -w;
                end
        end else begin
            e_valid = req_valid;
            if (req_valid) begin
                for (int w = 0; w < 2; w++) begin
                    if (m_v[set][w] && m_start[set][w] == req_addr) begin
                        int l; bit run;
                        l = 0; run = 1;
                        for (int b = 0; b < 2; b++)
                            if (run && b < m_nbr[set][w] && m_flags[set][w][b] == req_pred[b]) l++;
                            else run = 0;
                        if (!found || m_ends[set][w][l] > best_len ||
                            (m_ends[set][w][l] == best_len && m_stamp[set][w] > m_stamp[set][best_w])) begin
                            found = 1; best_w = w; best_len = m_ends[set][w][l]; best_l = l;
                        end
                    end
                end
                if (found) begin
                    e_hit    = 1;
                    e_full   = (best_l == m_nbr[set][best_w]);
                    e_count  = best_len;
                    e_blocks = best_l + 1;
                    e_nv     = e_full;
                    if (e_full)
                        e_next = req_pred[m_nbr[set][best_w]] ? m_targ[set][best_w] : m_fall[set][best_w];
                    for (int i = 0; i < 16; i++)
                        if (i < e_count) e_insns[i*32 +: 32] = {m_seed[set][best_w], 16'(i)};
                end
            end
            fs = int'(fill_start[6:2]);
            if (found && !(fill_valid && fs == set)) m_stamp[set][best_w] = now;
            if (fill_valid) begin
                fw = -1;
                for (int w = 0; w < 2; w++)
                    if (fw < 0 && m_v[fs][w] && m_start[fs][w] == fill_start &&
                        m_nbr[fs][w] == int'(fill_nbr) &&
                        m_flags[fs][w] == mask_flags(fill_flags, int'(fill_nbr))) fw = w;
                for (int w = 0; w < 2; w++)
                    if (fw < 0 && !m_v[fs][w]) fw = w;
                if (fw < 0) fw = (m_stamp[fs][0] < m_stamp[fs][1]) ? 0 : 1;
                m_v[fs][fw]     = 1;
                m_start[fs][fw] = fill_start;
                m_nbr[fs][fw]   = int'(fill_nbr);
                m_flags[fs][fw] = mask_flags(fill_flags, int'(fill_nbr));
                m_ends[fs][fw][0] = int'(fill_ends[4:0]);
                m_ends[fs][fw][1] = int'(fill_ends[9:5]);
                m_ends[fs][fw][2] = int'(fill_ends[14:10]);
                m_seed[fs][fw]  = cur_seed;
                m_fall[fs][fw]  = fill_fall;
                m_targ[fs][fw]  = fill_targ;
                m_stamp[fs][fw] = now;
            end
        end
        @(negedge clk);
        checks++;
        ok = (rsp_valid == e_valid) && (rsp_hit == e_hit) && (rsp_full == e_full) &&
             (int'(rsp_count) == e_count) && (int'(rsp_blocks) == e_blocks) &&
             (rsp_next_valid == e_nv) && (rsp_next_addr == e_next) && (rsp_insns == e_insns);
        if (!ok) begin
            errors++;
            $display("FAIL %s: got v=%0b hit=%0b full=%0b cnt=%0d blk=%0d nv=%0b next=%h ins0=%h, expected v=%0b hit=%0b full=%0b cnt=%0d blk=%0d nv=%0b next=%h ins0=%h",
                     tag, rsp_valid, rsp_hit, rsp_full, rsp_count, rsp_blocks, rsp_next_valid,
                     rsp_next_addr, rsp_insns[31:0], e_valid, e_hit, e_full, e_count, e_blocks,
                     e_nv, e_next, e_insns[31:0]);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] pool [6];
        rst_n = 1'b0; idle();
        req_addr = '0; req_pred = '0; fill_start = '0; fill_nbr = '0; fill_flags = '0;
        fill_ends = '0; fill_insns = '0; fill_fall = '0; fill_targ = '0; cur_seed = '0;
        @(negedge clk);
        cyc("R1 reset");
        set_look(32'h100, 3'b000);
        cyc("R1 reset lookup held");
        rst_n = 1'b1;
        cyc("R1 miss after reset");
        idle();
        cyc("R2 idle");

        // Trace A at 0x100: two outcomes (1, 0), ends 5/9/14.
        set_fill(32'h100, 2, 2'b01, 5, 9, 14, 16'hA000, 32'h200, 32'h300);
        cyc("R10 fill A");
        idle();
        set_look(32'h100, 3'b101);
        cyc("R3 full A, R9 taken exit");
        set_look(32'h100, 3'b001);
        cyc("R9 fall-through exit");
        set_look(32'h100, 3'b011);
        cyc("R4 partial second flag");
        set_look(32'h100, 3'b000);
        cyc("R4 partial first flag, R5 lanes");
        set_look(32'h180, 3'b101);
        cyc("R6 same index other start");
        set_look(32'h104, 3'b101);
        cyc("R5 miss other set");
        idle();
        cyc("R2 idle after lookups");

        // Trace B at 0x100: outcomes (1, 1), ends 5/7/12.
        set_fill(32'h100, 2, 2'b11, 5, 7, 12, 16'hB000, 32'h400, 32'h500);
        cyc("R7 fill B");
        idle();
        set_look(32'h100, 3'b011);
        cyc("R7 path B");
        set_look(32'h100, 3'b001);
        cyc("R7 path A");
        set_look(32'h100, 3'b000);
        cyc("R8 tie goes to recent A");
        set_look(32'h100, 3'b011);
        cyc("R11 touch B");
        set_look(32'h100, 3'b000);
        cyc("R8 tie goes to recent B");
        set_look(32'h100, 3'b101);
        set_fill(32'h100, 2, 2'b01, 5, 9, 14, 16'hA100, 32'h210, 32'h310);
        cyc("R12 lookup sees old A, R11 fill wins");
        idle();
        set_look(32'h100, 3'b101);
        cyc("R10 rewrite in place");
        set_look(32'h100, 3'b000);
        cyc("R11 fill touch took effect");
        set_fill(32'h100, 1, 2'b10, 3, 8, 8, 16'hC000, 32'h600, 32'h700);
        idle(); fill_valid = 1'b1;
        cyc("R10 third path evicts LRU");
        idle();
        set_look(32'h100, 3'b000);
        cyc("R3 extra predictions ignored, C");
        set_look(32'h100, 3'b011);
        cyc("R10 evicted path gone");
        set_fill(32'h100, 0, 2'b11, 4, 4, 4, 16'hD000, 32'h800, 32'h900);
        cyc("R10 zero outcome fill");
        idle();
        set_look(32'h100, 3'b111);
        cyc("R3 single block full");

        // Random phase on two sets, six starts.
        pool[0] = 32'h0000_0040; pool[1] = 32'h0000_00C0; pool[2] = 32'h1000_0040;
        pool[3] = 32'h0000_0044; pool[4] = 32'h0000_00C4; pool[5] = 32'h2000_0044;
        for (int k = 0; k < 3000; k++) begin
            idle();
            if ($urandom_range(0, 2) == 0) begin
                int n, e0, e1, e2;
                n  = $urandom_range(0, 2);
                e0 = $urandom_range(1, 5);
                e1 = e0 + $urandom_range(1, 5);
                e2 = e1 + $urandom_range(1, 5);
                set_fill(pool[$urandom_range(0, 5)], n, 2'($urandom_range(0, 3)), e0, e1, e2,
                         16'($urandom), $urandom, $urandom);
            end
            if ($urandom_range(0, 3) != 0)
                set_look(pool[$urandom_range(0, 5)], 3'($urandom_range(0, 7)));
            cyc("R8 random mix");
        end
        idle();
        cyc("R2 final idle");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule